// File: doc/BRIEF.md
# Dual-Mode PRBS Link Checker

This block sits on the receive side of a serial link, after the parallel word has been recovered. When the test enable is high it checks the incoming 24-bit words against a pseudo-random reference that it generates itself. All-zero words sent before the pattern starts are treated as idle and skipped. The first non-zero word seeds the reference, so no shared start signal with the transmitter is needed. From then on every word is compared.

Errors are reported on the same 24 output lines that carry received data in normal operation, in one of two selectable forms. The first is a per-bit mismatch vector. The second is a saturating 8-bit count of mismatched bits. A pass flag rises once a configurable run of consecutive error-free words has been seen. The default run length is the number of 24-bit words that covers 10^9 bits. The flag is only valid while the recovered-clock lock input is high. Dropping either lock or enable discards all progress.

Top module: `prbs_link_checker`

## Requirements
- R1: With `test_en_i` low, `rx_out_o` equals the `rx_word_i` value sampled at the previous clock edge, and `pass_o` is low.
- R2: While enabled and not yet aligned, all-zero input words are ignored. No alignment occurs, the tally stays 0 and the mismatch vector stays 0.
- R3: The first non-zero word seen while enabled and locked seeds the reference and is not itself checked. Word k carries sequence bits s[24k+i] on bit i, with s[n] = s[n-18] XOR s[n-23].
- R4: With `mode_cnt_i` low (0 selects the bit vector), `rx_out_o` bit i is high one cycle after a compared word whose bit i differed from the reference.
- R5: With `mode_cnt_i` high, `rx_out_o[7:0]` holds the running sum of mismatched bits over all compared words, and `rx_out_o[23:8]` is 0. The sum includes the word sampled at the previous edge.
- R6: The tally saturates at 255 and never wraps.
- R7: `pass_o` goes high in the cycle after the PASS_WORDS-th consecutive error-free compared word. The seed word does not count.
- R8: A compared word with any mismatch restarts the error-free run, and `pass_o` is low in the following cycle.
- R9: With `lock_i` low at an edge, `pass_o` is low in the following cycle, and the tally, the error-free run and the alignment are cleared.
- R10: With `test_en_i` low at an edge, the tally, the error-free run and the alignment are cleared.
- R11: While `rst_ni` is asserted, `rx_out_o` is 0 and `pass_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Recovered word clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| test_en_i | input | 1 | Arms the self-test; low passes data through |
| mode_cnt_i | input | 1 | 0: per-bit mismatch report, 1: error tally report |
| lock_i | input | 1 | Recovered-clock lock indication |
| rx_word_i | input | 24 | Received parallel word |
| rx_out_o | output | 24 | Data, mismatch vector or tally, registered |
| pass_o | output | 1 | Error-free budget met while locked |

## Verification
The case that matters most is a word with mismatches arriving in the very cycle in which the error-free run would otherwise reach its budget. The error restart and the pass completion then compete. The bench provokes this by sending exactly one word fewer than the budget of clean words, followed by a single-bit error word. It then requires `pass_o` to stay low and a full fresh run to be needed afterwards. A second overlap occurs when multi-bit error words push the tally across 255. There, each output is checked against a bench-computed clamped sum.

// File: rtl/lkchk_pkg.sv
package lkchk_pkg;
  typedef enum logic {
    RPT_BITS  = 1'b0,
    RPT_TALLY = 1'b1
  } rpt_mode_e;

  localparam int unsigned LFSR_LEN = 23;
  localparam int unsigned LFSR_TAP = 18;
endpackage

// File: rtl/lkchk_ref.sv
module lkchk_ref #(
  parameter int unsigned W   = 24,
  parameter int unsigned LEN = lkchk_pkg::LFSR_LEN,
  parameter int unsigned TAP = lkchk_pkg::LFSR_TAP
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] rx_word_i,
  output logic         cmp_valid_o,
  output logic [W-1:0] mism_o
);
  localparam int unsigned EXT_W = 2 * W;

  logic         aligned_q, aligned_d;
  logic [W-1:0] exp_q, exp_d;
  logic         ref_en;

  // Extend a word by W sequence bits: ext[j] = ext[j-LEN] ^ ext[j-TAP].
  function automatic logic [W-1:0] advance(input logic [W-1:0] cur);
    logic [EXT_W-1:0] ext;
    ext = '0;
    ext[W-1:0] = cur;
    for (int j = W; j < EXT_W; j++) begin
      ext[j] = ext[j-LEN] ^ ext[j-TAP];
    end
    return ext[EXT_W-1:W];
  endfunction

  generate
    if (W < LEN) begin : g_bad_width
      initial $error("word narrower than generator length");
    end
  endgenerate

  always_comb begin
    aligned_d = aligned_q;
    exp_d     = exp_q;
    ref_en    = 1'b0;
    if (!run_i) begin
      aligned_d = 1'b0;
    end else if (!aligned_q) begin
      if (rx_word_i != '0) begin
        aligned_d = 1'b1;
        exp_d     = advance(rx_word_i);
        ref_en    = 1'b1;
      end
    end else begin
      exp_d  = advance(exp_q);
      ref_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_q <= 1'b0;
      exp_q     <= '0;
    end else begin
      aligned_q <= aligned_d;
      if (ref_en) exp_q <= exp_d;
    end
  end

  assign cmp_valid_o = run_i & aligned_q;
  assign mism_o      = cmp_valid_o ? (rx_word_i ^ exp_q) : '0;

  // R2: idle zero words never align the checker
  a_r2_idle_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !aligned_q && rx_word_i == '0) |=> !aligned_q);
  // R9 / R10: loss of run drops alignment
  a_r9_align_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !aligned_q);
endmodule

// File: rtl/lkchk_tally.sv
module lkchk_tally #(
  parameter int unsigned W     = 24,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cmp_valid_i,
  input  logic [W-1:0]     mism_i,
  output logic [CNT_W-1:0] tally_d_o
);
  localparam int unsigned POP_W = $clog2(W + 1);
  localparam int unsigned SUM_W = CNT_W + POP_W;
  localparam logic [CNT_W-1:0] TALLY_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] tally_q, tally_d;
  logic [POP_W-1:0] pop;
  logic [SUM_W-1:0] sum;

  always_comb begin
    pop = '0;
    for (int i = 0; i < W; i++) begin
      pop = pop + POP_W'(mism_i[i]);
    end
    sum = SUM_W'(tally_q) + SUM_W'(pop);
  end

  always_comb begin
    tally_d = tally_q;
    if (!run_i) begin
      tally_d = '0;
    end else if (cmp_valid_i) begin
      tally_d = (sum > SUM_W'(TALLY_MAX)) ? TALLY_MAX : sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tally_q <= '0;
    else         tally_q <= tally_d;
  end

  assign tally_d_o = tally_d;

  // R6: once full, the tally stays full while running
  a_r6_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tally_q == TALLY_MAX) |=> tally_q == TALLY_MAX);
  // R5: tally never decreases while running
  a_r5_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> tally_q >= $past(tally_q));
endmodule

// File: rtl/lkchk_pass.sv
module lkchk_pass #(
  parameter int unsigned PASS_WORDS = 41666667
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic cmp_valid_i,
  input  logic err_i,
  output logic pass_o
);
  localparam int unsigned RUN_W = $clog2(PASS_WORDS + 1);
  localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(PASS_WORDS);

  logic [RUN_W-1:0] clean_q, clean_d;
  logic             pass_q, pass_d;

  always_comb begin
    clean_d = clean_q;
    if (!run_i) begin
      clean_d = '0;
    end else if (cmp_valid_i) begin
      if (err_i)                    clean_d = '0;
      else if (clean_q != RUN_LIMIT) clean_d = clean_q + 1'b1;
    end
    pass_d = run_i && (clean_d == RUN_LIMIT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clean_q <= '0;
      pass_q  <= 1'b0;
    end else begin
      clean_q <= clean_d;
      pass_q  <= pass_d;
    end
  end

  assign pass_o = pass_q;

  // R8: an erroneous compared word forces pass low next cycle
  a_r8_err_drops_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && err_i) |=> !pass_o);
  // R7: pass can only rise right after a clean compared word
  a_r7_rise_on_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pass_o) |-> $past(cmp_valid_i && !err_i));
endmodule

// File: rtl/prbs_link_checker.sv
module prbs_link_checker #(
  parameter int unsigned W          = 24,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned PASS_WORDS = 41666667
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         test_en_i,
  input  logic         mode_cnt_i,
  input  logic         lock_i,
  input  logic [W-1:0] rx_word_i,
  output logic [W-1:0] rx_out_o,
  output logic         pass_o
);
  import lkchk_pkg::*;

  localparam int unsigned HI_W = W - CNT_W;

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             run;
  logic             cmp_valid;
  logic [W-1:0]     mism;
  logic [CNT_W-1:0] tally_d;
  logic [W-1:0]     out_q, out_d;
  rpt_mode_e        mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign run  = test_en_i & lock_i;
  assign mode = rpt_mode_e'(mode_cnt_i);

  lkchk_ref #(.W(W)) u_ref (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .run_i       (run),
    .rx_word_i   (rx_word_i),
    .cmp_valid_o (cmp_valid),
    .mism_o      (mism)
  );

  lkchk_tally #(.W(W), .CNT_W(CNT_W)) u_tally (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .run_i       (run),
    .cmp_valid_i (cmp_valid),
    .mism_i      (mism),
    .tally_d_o   (tally_d)
  );

  lkchk_pass #(.PASS_WORDS(PASS_WORDS)) u_pass (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .run_i       (run),
    .cmp_valid_i (cmp_valid),
    .err_i       (|mism),
    .pass_o      (pass_o)
  );

  always_comb begin
    if (!test_en_i)               out_d = rx_word_i;
    else if (mode == RPT_TALLY)   out_d = {{HI_W{1'b0}}, tally_d};
    else                          out_d = mism;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign rx_out_o = out_q;

  // R9: no lock at an edge means pass is low after it
  a_r9_lock_gates_pass: assert property (@(posedge clk_i) disable iff (!rst_n)
    !lock_i |=> !pass_o);
  // R5: accumulator mode keeps the upper lines at zero
  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (test_en_i && mode_cnt_i) |=> rx_out_o[W-1:CNT_W] == '0);
  // R4: bit mode reports nothing when no comparison took place
  a_r4_quiet_unaligned: assert property (@(posedge clk_i) disable iff (!rst_n)
    (test_en_i && !mode_cnt_i && !cmp_valid) |=> rx_out_o == '0);
  // R1: pass stays low while the test is disabled
  a_r1_disabled_no_pass: assert property (@(posedge clk_i) disable iff (!rst_n)
    !test_en_i |=> !pass_o);
endmodule

// File: tb/prbs_link_checker_test.sv
`timescale 1ns/1ps
module prbs_link_checker_test;
  localparam int unsigned W = 24;
  localparam int unsigned PW = 20;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en, mode, lock;
  logic [W-1:0] rx;
  logic [W-1:0] out;
  logic         pass;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [22:0] hist;

  always #2.5 clk = ~clk;

  prbs_link_checker #(.W(W), .CNT_W(8), .PASS_WORDS(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .test_en_i(en), .mode_cnt_i(mode),
    .lock_i(lock), .rx_word_i(rx), .rx_out_o(out), .pass_o(pass)
  );

  // {mode, error mask, expected output}
  localparam logic [48:0] VEC [8] = '{
    {1'b0, 24'h000000, 24'h000000},
    {1'b0, 24'h000001, 24'h000001},
    {1'b0, 24'h800000, 24'h800000},
    {1'b1, 24'h0000F0, 24'h000006},
    {1'b1, 24'h000000, 24'h000006},
    {1'b0, 24'h0F0F0F, 24'h0F0F0F},
    {1'b1, 24'hFFFFFF, 24'h00002A},
    {1'b1, 24'h000300, 24'h00002C}
  };

  task automatic seed(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) hist = {hist[21:0], w[i]};
  endtask

  function automatic logic [W-1:0] gen_next();
    logic [W-1:0] w;
    logic b;
    for (int i = 0; i < W; i++) begin
      b = hist[17] ^ hist[22];
      w[i] = b;
      hist = {hist[21:0], b};
    end
    return w;
  endfunction

  task automatic step(input logic [W-1:0] w);
    rx = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t;
    logic [W-1:0] w;
    rst_n = 1'b0; en = 1'b0; mode = 1'b0; lock = 1'b0; rx = '0;
    hist = '0;
    repeat (3) @(negedge clk);
    rx = 24'h5A5A5A;
    @(negedge clk);
    chk("R11 out", out, '0);
    chk("R11 pass", {23'b0, pass}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b1; lock = 1'b1;

    for (int i = 0; i < 3; i++) begin
      step('0);
      chk("R2 idle", out, '0);
    end
    seed(24'hA5F00D);
    step(24'hA5F00D);
    chk("R3 seed unchecked", out, '0);

    for (int i = 0; i < 8; i++) begin
      mode = VEC[i][48];
      step(gen_next() ^ VEC[i][47:24]);
      chk(VEC[i][48] ? "R5 tally" : "R4 bitvec", out, VEC[i][23:0]);
      chk("R8 pass low", {23'b0, pass}, '0);
    end

    mode = 1'b1;
    t = 44;
    for (int i = 0; i < 10; i++) begin
      step(gen_next() ^ 24'hFFFFFF);
      t = (t + 24 > 255) ? 255 : t + 24;
      chk("R6 saturate", out, 24'(t));
    end

    for (int i = 0; i < PW - 1; i++) begin
      step(gen_next());
      chk("R7 not yet", {23'b0, pass}, '0);
    end
    step(gen_next() ^ 24'h000001);
    chk("R8 collision", {23'b0, pass}, '0);
    for (int i = 0; i < PW; i++) begin
      step(gen_next());
      chk("R7 budget", {23'b0, pass}, (i == PW - 1) ? 24'd1 : 24'd0);
    end
    step(gen_next() ^ 24'h400000);
    chk("R8 error drop", {23'b0, pass}, '0);
    for (int i = 0; i < PW; i++) step(gen_next());
    chk("R7 regained", {23'b0, pass}, 24'd1);

    lock = 1'b0;
    step(gen_next());
    chk("R9 pass", {23'b0, pass}, '0);
    chk("R9 tally", out, '0);
    lock = 1'b1;
    step(24'h3C5A97);
    chk("R9 realign seed", out, '0);
    seed(24'h3C5A97);
    step(gen_next());
    chk("R9 realigned clean", out, '0);
    step(gen_next() ^ 24'h000011);
    chk("R9 realigned tally", out, 24'd2);

    en = 1'b0;
    step(24'h123456);
    chk("R1 mirror", out, 24'h123456);
    chk("R1 pass", {23'b0, pass}, '0);
    step(24'hABCDEF);
    chk("R1 mirror2", out, 24'hABCDEF);
    en = 1'b1;
    step('0);
    chk("R10 tally cleared", out, '0);
    step(24'h00C0DE);
    chk("R10 realign", out, '0);
    seed(24'h00C0DE);
    w = gen_next();
    step(w);
    chk("R10 clean", out, '0);
    mode = 1'b0;
    step(gen_next() ^ 24'h010000);
    chk("R4 after realign", out, 24'h010000);

    finish_run();
  end
endmodule